// File: doc/BRIEF.md
# Address Chip-Select Generator

This block turns a 16-bit bus address into one-of-N external chip-select lines: a number of I/O selects, one general-purpose select and one program select. Each external select compares the address with its own base register. It ignores the address bits that fall inside its block size. The on-chip memories (register file, RAM, boot ROM, EEPROM) are reported to the block as hit flags. Any of those hits outranks every external select, so no external select fires while an on-chip region answers.

The winner among the external selects is chosen by a fixed ranking: the I/O selects first, then the general-purpose and program selects. A control bit swaps the order of those last two. A select can be asserted for the whole address-valid time, or only while the bus clock is in its high phase. Its output polarity is programmable. It can also ask for zero to three extra bus-clock cycles of stretch. During the stretch the block raises a stretch request and freezes the granted select. The address and the phase inputs have no effect until the programmed count runs out.

The block is pure control logic. All pins are plain level signals with no valid/ready handshake. The address is taken as meaningful only while `addr_valid` is high, and the bus master is expected to keep the cycle open while `stretch_req` is high.

Top module: `cs_gen`

## Requirements
- R1: The general-purpose size code `gp_size` gives the block size 64 KB >> code for codes 0..6, so 0 = 64 KB and 6 = 1 KB. Code 7 disables the general-purpose select.
- R2: The program size code `prog_size` gives the block size 64 KB >> code, so 0 = 64 KB and 3 = 8 KB. The program select cannot be disabled.
- R3: Each I/O size code gives the block size 2 KB >> code, so 0 = 2 KB and 3 = 256 bytes. For every select, only the address bits above the block size are compared with the base. The lower base and address bits have no effect.
- R4: While any bit of `onchip_hit` is high, no external select is asserted, unless a stretch that was already granted is in progress.
- R5: Ranking, highest first: I/O select 0, I/O select 1, and so on up to I/O select NUM_IO-1, then the general-purpose select, then the program select. Select index order is io0..io(NUM_IO-1), then gp (index NUM_IO), then prog (index NUM_IO+1).
- R6: When `prog_over_gp` is 1, the program select outranks the general-purpose select. All other rankings are unchanged.
- R7: An I/O or general-purpose select whose full-time bit is 0 is asserted only while `clk_high` is 1. With the bit at 1 it is asserted for the whole time `addr_valid` is 1. The program select always uses whole address-valid timing.
- R8: With `addr_valid` low and no stretch in progress, no select is asserted.
- R9: Each `cs_out` bit equals 1 when asserted if its `sel_act_high` bit is 1, and 0 when asserted if that bit is 0. An inactive select shows the opposite level.
- R10: In the first cycle of an access, the winning select's 2-bit field in `sel_stretch` (bits 2i+1:2i for select i) is sampled. `stretch_req` is then high for exactly that many cycles following that cycle. A field of 0 gives no stretch.
- R11: While `stretch_req` is high, exactly the select granted at the start of the access is asserted, whatever the address, phase or on-chip inputs do.
- R12: An access is granted at most one stretch. It re-arms only after `addr_valid` has been low at a clock edge.
- R13: At most one select is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| addr_valid | input | 1 | Address phase valid |
| clk_high | input | 1 | Bus clock high phase (data strobe window) |
| onchip_hit | input | 4 | Hit flags of on-chip register file, RAM, boot ROM, EEPROM |
| prog_base | input | 16 | Program select base address |
| prog_size | input | 2 | Program select size code |
| gp_base | input | 16 | General-purpose select base address |
| gp_size | input | 3 | General-purpose select size code (7 = off) |
| gp_full_time | input | 1 | General-purpose select timing: 1 = whole address time |
| io_base | input | 32 | I/O select bases, select i in bits 16i+15:16i |
| io_size | input | 4 | I/O size codes, select i in bits 2i+1:2i |
| io_full_time | input | 2 | I/O select timing bits, one per I/O select |
| sel_act_high | input | 4 | Output polarity per select (1 = active high) |
| sel_stretch | input | 8 | Stretch cycles per select, select i in bits 2i+1:2i |
| prog_over_gp | input | 1 | 1 = program select outranks general-purpose select |
| cs_out | output | 4 | Select lines: io0, io1, gp, prog at bits 0..3 |
| stretch_req | output | 1 | Bus-cycle stretch request |

## Verification
The hardest state to reach from the ports is a stretch in progress while the inputs that chose the winner move under it. In that state the address, the phase and the on-chip flags all change, yet the held select must not move. The stimulus gets there by opening every access with a select whose stretch field is non-zero. On each stretch cycle it then scrambles the address, the phase and the on-chip flags. Afterwards it restores the original inputs with `addr_valid` still high, which shows that the access does not re-arm. Random configurations aim addresses just inside and just outside chosen bases, so size masking and ranking are exercised at block edges.

// File: rtl/cs_pkg.sv
package cs_pkg;

  // Per-select decode settings derived from the size and timing inputs.
  typedef struct packed {
    logic [4:0] ign;   // number of low address bits excluded from compare
    logic       en;    // select may hit at all
    logic       full;  // 1: whole address time, 0: clock-high phase only
  } sel_cfg_t;

  // Shared helper: low bits ignored for a size code counted down from a top.
  function automatic logic [4:0] size_to_ign(input logic [2:0] code,
                                             input int unsigned top_log);
    return 5'(int'(top_log) - int'(code));
  endfunction

endpackage

// File: rtl/cs_range_match.sv
module cs_range_match #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [4:0]        ign,
  input  logic              en,
  output logic              hit
);
  logic [ADDR_W-1:0] keep;

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      keep[i] = (i >= int'(ign));
    end
    hit = en && (((addr ^ base) & keep) == '0);
  end
endmodule

// File: rtl/cs_arbiter.sv
module cs_arbiter #(
  parameter int unsigned NUM_IO = 2,
  localparam int unsigned NSEL = NUM_IO + 2,
  localparam int unsigned GP_IDX = NUM_IO,
  localparam int unsigned PROG_IDX = NUM_IO + 1
) (
  input  logic [NSEL-1:0] req,
  input  logic            onchip_any,
  input  logic            prog_first,
  output logic [NSEL-1:0] win
);
  always_comb begin
    int  idx;
    logic taken;
    win   = '0;
    taken = 1'b0;
    idx   = 0;
    if (!onchip_any) begin
      for (int r = 0; r < int'(NSEL); r++) begin
        if (r < int'(NUM_IO))       idx = r;
        else if (r == int'(NUM_IO)) idx = prog_first ? int'(PROG_IDX) : int'(GP_IDX);
        else                        idx = prog_first ? int'(GP_IDX) : int'(PROG_IDX);
        if (!taken && req[idx]) begin
          win[idx] = 1'b1;
          taken    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cs_stretch.sv
module cs_stretch #(
  parameter int unsigned NSEL  = 4,
  parameter int unsigned STR_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_valid,
  input  logic [NSEL-1:0]       win,
  input  logic [NSEL*STR_W-1:0] stretch_cfg,
  output logic                  stretch_req,
  output logic [NSEL-1:0]       held
);
  logic [STR_W-1:0] cnt;
  logic [STR_W-1:0] n_win;
  logic             served;
  logic             first;

  always_comb begin
    n_win = '0;
    for (int g = 0; g < int'(NSEL); g++) begin
      if (win[g]) n_win = n_win | stretch_cfg[g*STR_W +: STR_W];
    end
  end

  assign first       = addr_valid && !served && (cnt == '0);
  assign stretch_req = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      served <= 1'b0;
      held   <= '0;
    end else begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (first && (|win) && (n_win != '0)) begin
        cnt  <= n_win;
        held <= win;
      end
      if (!addr_valid)      served <= 1'b0;
      else if (cnt == '0)   served <= 1'b1;
    end
  end
endmodule

// File: rtl/cs_gen.sv
module cs_gen
  import cs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned NUM_IO     = 2,
  parameter int unsigned IO_MAX_LOG = 11,
  parameter int unsigned NUM_ONCHIP = 4,
  parameter int unsigned STR_W      = 2,
  localparam int unsigned NSEL      = NUM_IO + 2,
  localparam int unsigned GP_IDX    = NUM_IO,
  localparam int unsigned PROG_IDX  = NUM_IO + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     addr_valid,
  input  logic                     clk_high,
  input  logic [NUM_ONCHIP-1:0]    onchip_hit,
  input  logic [ADDR_W-1:0]        prog_base,
  input  logic [1:0]               prog_size,
  input  logic [ADDR_W-1:0]        gp_base,
  input  logic [2:0]               gp_size,
  input  logic                     gp_full_time,
  input  logic [NUM_IO*ADDR_W-1:0] io_base,
  input  logic [NUM_IO*2-1:0]      io_size,
  input  logic [NUM_IO-1:0]        io_full_time,
  input  logic [NSEL-1:0]          sel_act_high,
  input  logic [NSEL*STR_W-1:0]    sel_stretch,
  input  logic                     prog_over_gp,
  output logic [NSEL-1:0]          cs_out,
  output logic                     stretch_req
);
  sel_cfg_t          cfg  [NSEL];
  logic [ADDR_W-1:0] base [NSEL];
  logic [NSEL-1:0]   match;
  logic [NSEL-1:0]   req;
  logic [NSEL-1:0]   win;
  logic [NSEL-1:0]   phase_ok;
  logic [NSEL-1:0]   held;
  logic [NSEL-1:0]   active;

  for (genvar g = 0; g < int'(NUM_IO); g++) begin : g_io_cfg
    assign base[g]     = io_base[g*ADDR_W +: ADDR_W];
    assign cfg[g].ign  = size_to_ign({1'b0, io_size[g*2 +: 2]}, IO_MAX_LOG);
    assign cfg[g].en   = 1'b1;
    assign cfg[g].full = io_full_time[g];
  end

  assign base[GP_IDX]     = gp_base;
  assign cfg[GP_IDX].ign  = size_to_ign(gp_size, ADDR_W);
  assign cfg[GP_IDX].en   = (gp_size != 3'b111);
  assign cfg[GP_IDX].full = gp_full_time;

  assign base[PROG_IDX]     = prog_base;
  assign cfg[PROG_IDX].ign  = size_to_ign({1'b0, prog_size}, ADDR_W);
  assign cfg[PROG_IDX].en   = 1'b1;
  assign cfg[PROG_IDX].full = 1'b1;

  for (genvar g = 0; g < int'(NSEL); g++) begin : g_match
    cs_range_match #(.ADDR_W(ADDR_W)) u_match (
      .addr (bus_addr),
      .base (base[g]),
      .ign  (cfg[g].ign),
      .en   (cfg[g].en),
      .hit  (match[g])
    );
    assign phase_ok[g] = cfg[g].full | clk_high;
  end

  assign req = match & {NSEL{addr_valid}};

  cs_arbiter #(.NUM_IO(NUM_IO)) u_arb (
    .req        (req),
    .onchip_any (|onchip_hit),
    .prog_first (prog_over_gp),
    .win        (win)
  );

  cs_stretch #(.NSEL(NSEL), .STR_W(STR_W)) u_str (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_valid  (addr_valid),
    .win         (win),
    .stretch_cfg (sel_stretch),
    .stretch_req (stretch_req),
    .held        (held)
  );

  assign active = stretch_req ? held : (win & phase_ok);
  assign cs_out = ~(active ^ sel_act_high);
endmodule

// File: rtl/cs_gen_chk.sv
module cs_gen_chk #(
  parameter int unsigned NSEL       = 4,
  parameter int unsigned GP_IDX     = 2,
  parameter int unsigned NUM_ONCHIP = 4,
  parameter int unsigned STR_W      = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  addr_valid,
  input logic                  clk_high,
  input logic [NUM_ONCHIP-1:0] onchip_hit,
  input logic                  gp_full_time,
  input logic [NSEL-1:0]       sel_act_high,
  input logic [NSEL-1:0]       cs_out,
  input logic                  stretch_req
);
  localparam int unsigned MAX_STR = (1 << STR_W) - 1;

  logic [NSEL-1:0] act;
  logic [7:0]      run;

  assign act = ~(cs_out ^ sel_act_high);

  always_ff @(posedge clk) begin
    if (!rst_n)           run <= '0;
    else if (stretch_req) run <= (run == 8'hFF) ? run : run + 8'd1;
    else                  run <= '0;
  end

  p_one_sel_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  p_onchip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|onchip_hit && !stretch_req) |-> (act == '0));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !stretch_req) |-> (act == '0));

  p_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_high && !gp_full_time && !stretch_req) |-> !act[GP_IDX]);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch_req && $past(stretch_req)) |-> (act == $past(act)));

  p_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_req |-> (run < 8'(MAX_STR)));

  p_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stretch_req) |-> $past(addr_valid));
endmodule

bind cs_gen cs_gen_chk #(
  .NSEL(NSEL), .GP_IDX(GP_IDX), .NUM_ONCHIP(NUM_ONCHIP), .STR_W(STR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_valid   (addr_valid),
  .clk_high     (clk_high),
  .onchip_hit   (onchip_hit),
  .gp_full_time (gp_full_time),
  .sel_act_high (sel_act_high),
  .cs_out       (cs_out),
  .stretch_req  (stretch_req)
);

// File: tb/cs_gen_test.sv
`timescale 1ns/1ps
module cs_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        addr_valid;
  logic        clk_high;
  logic [3:0]  onchip_hit;
  logic [3:0]  cs_out;
  logic        stretch_req;

  // bench-side configuration
  logic [15:0] c_io_base [2];
  logic [1:0]  c_io_size [2];
  logic [1:0]  c_io_full;
  logic [15:0] c_gp_base, c_prog_base;
  logic [2:0]  c_gp_size;
  logic [1:0]  c_prog_size;
  logic        c_gp_full;
  logic [3:0]  c_act_hi;
  logic [1:0]  c_str [4];
  logic        c_pf;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cs_gen uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .addr_valid(addr_valid),
    .clk_high(clk_high), .onchip_hit(onchip_hit),
    .prog_base(c_prog_base), .prog_size(c_prog_size),
    .gp_base(c_gp_base), .gp_size(c_gp_size), .gp_full_time(c_gp_full),
    .io_base({c_io_base[1], c_io_base[0]}), .io_size({c_io_size[1], c_io_size[0]}),
    .io_full_time(c_io_full), .sel_act_high(c_act_hi),
    .sel_stretch({c_str[3], c_str[2], c_str[1], c_str[0]}),
    .prog_over_gp(c_pf), .cs_out(cs_out), .stretch_req(stretch_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit in_blk(input int a, input int b, input int k);
    return (a >> k) == (b >> k);
  endfunction

  // model: index of winning select or -1
  function automatic int ref_win(input int a, input logic [3:0] oc);
    int gp_k;
    int pr_k;
    bit gp_h;
    bit pr_h;
    if (oc != 0) return -1;
    for (int i = 0; i < 2; i++)
      if (in_blk(a, c_io_base[i], 11 - int'(c_io_size[i]))) return i;
    gp_k = (c_gp_size == 3'd7) ? -1 : 16 - int'(c_gp_size);
    pr_k = 16 - int'(c_prog_size);
    gp_h = (gp_k >= 0) && in_blk(a, c_gp_base, gp_k);
    pr_h = in_blk(a, c_prog_base, pr_k);
    if (c_pf) begin
      if (pr_h) return 3;
      if (gp_h) return 2;
    end else begin
      if (gp_h) return 2;
      if (pr_h) return 3;
    end
    return -1;
  endfunction

  function automatic logic [3:0] exp_act(input int a, input bit v, input bit ph,
                                         input logic [3:0] oc);
    int w;
    bit full;
    logic [3:0] r;
    r = 4'b0;
    w = ref_win(a, oc);
    if (v && w >= 0) begin
      full = (w < 2) ? c_io_full[w] : (w == 2) ? c_gp_full : 1'b1;
      if (full || ph) r[w] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [3:0] to_pins(input logic [3:0] act);
    return ~(act ^ c_act_hi);
  endfunction

  // one bus access with its stretch phase and the idle gap after it
  task automatic access(input int a, input bit ph, input logic [3:0] oc, input string tag);
    int w;
    int n;
    logic [3:0] e;
    logic [3:0] held;
    @(negedge clk);
    bus_addr = 16'(a); addr_valid = 1'b1; clk_high = ph; onchip_hit = oc;
    #2;
    e = exp_act(a, 1'b1, ph, oc);
    chk(cs_out == to_pins(e), tag, cs_out, to_pins(e));
    chk($countones(~(cs_out ^ c_act_hi)) <= 1, "R13", cs_out, to_pins(e));
    chk(stretch_req == 1'b0, "R10", stretch_req, 0);
    w = ref_win(a, oc);
    n = (w >= 0) ? int'(c_str[w]) : 0;
    held = 4'b0;
    if (w >= 0) held[w] = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_addr = 16'($urandom); clk_high = 1'($urandom); onchip_hit = 4'($urandom);
      #2;
      chk(stretch_req == 1'b1, "R10", stretch_req, 1);
      chk(cs_out == to_pins(held), "R11", cs_out, to_pins(held));
    end
    @(negedge clk);
    bus_addr = 16'(a); clk_high = ph; onchip_hit = oc;
    #2;
    chk(stretch_req == 1'b0, "R12", stretch_req, 0);
    chk(cs_out == to_pins(e), "R12", cs_out, to_pins(e));
    @(negedge clk);
    addr_valid = 1'b0; clk_high = 1'($urandom);
    #2;
    chk(cs_out == to_pins(4'b0), "R8", cs_out, to_pins(4'b0));
  endtask

  task automatic base_cfg();
    c_io_base[0] = 16'h4000; c_io_size[0] = 2'd0;
    c_io_base[1] = 16'h4800; c_io_size[1] = 2'd3;
    c_io_full    = 2'b11;
    c_gp_base    = 16'h8000; c_gp_size = 3'd3; c_gp_full = 1'b1;
    c_prog_base  = 16'h0000; c_prog_size = 2'd0;
    c_act_hi     = 4'b0101;
    for (int i = 0; i < 4; i++) c_str[i] = 2'd0;
    c_pf = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C5A1));
    base_cfg();
    rst_n = 1'b0; bus_addr = '0; addr_valid = 1'b0; clk_high = 1'b0; onchip_hit = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(cs_out == to_pins(4'b0) && !stretch_req, "R8", {stretch_req, cs_out}, to_pins(4'b0));
    @(negedge clk); rst_n = 1'b1;

    // R3: I/O blocks ignore low bits
    access(16'h47FF, 1'b1, 4'h0, "R3");
    access(16'h4800, 1'b1, 4'h0, "R3");
    access(16'h48FF, 1'b1, 4'h0, "R3");
    access(16'h4900, 1'b1, 4'h0, "R3");
    // R1: gp 8 KB edge and disable code
    access(16'h9FFF, 1'b1, 4'h0, "R1");
    access(16'hA000, 1'b1, 4'h0, "R1");
    c_gp_size = 3'd7;
    access(16'h8000, 1'b1, 4'h0, "R1");
    c_gp_size = 3'd6; c_gp_base = 16'hC400;
    access(16'hC7FF, 1'b1, 4'h0, "R1");
    access(16'hC800, 1'b1, 4'h0, "R1");
    // R2: program size
    base_cfg(); c_prog_size = 2'd3; c_prog_base = 16'hE000;
    access(16'h1234, 1'b1, 4'h0, "R2");
    access(16'hE010, 1'b1, 4'h0, "R2");
    // R5: ranking io over gp over prog
    base_cfg(); c_io_base[0] = 16'h8000;
    access(16'h8100, 1'b1, 4'h0, "R5");
    access(16'h8900, 1'b1, 4'h0, "R5");
    // R6: swap gp/prog
    c_pf = 1'b1;
    access(16'h8900, 1'b1, 4'h0, "R6");
    // R4: on-chip wins
    base_cfg();
    access(16'h4000, 1'b1, 4'b0100, "R4");
    access(16'h9000, 1'b1, 4'b0001, "R4");
    // R7: phase timing
    c_gp_full = 1'b0;
    access(16'h9000, 1'b0, 4'h0, "R7");
    access(16'h9000, 1'b1, 4'h0, "R7");
    c_io_full = 2'b00;
    access(16'h4000, 1'b0, 4'h0, "R7");
    access(16'h2000, 1'b0, 4'h0, "R7");
    // R9: polarity
    base_cfg(); c_act_hi = 4'b1010;
    access(16'h4000, 1'b1, 4'h0, "R9");
    access(16'h2000, 1'b1, 4'h0, "R9");
    // R10/R11/R12: stretch lengths, including stretch granted to a phase-gated select
    base_cfg(); c_str[3] = 2'd3; c_str[2] = 2'd1; c_str[0] = 2'd2; c_gp_full = 1'b0;
    access(16'h2000, 1'b1, 4'h0, "R10");
    access(16'h9000, 1'b0, 4'h0, "R10");
    access(16'h4000, 1'b1, 4'h0, "R12");
    access(16'h4000, 1'b1, 4'b1000, "R4");

    // random configurations, addresses aimed near the bases
    for (int it = 0; it < 400; it++) begin
      int a;
      int pick;
      for (int i = 0; i < 2; i++) begin
        c_io_base[i] = 16'($urandom); c_io_size[i] = 2'($urandom);
      end
      c_io_full   = 2'($urandom);
      c_gp_base   = 16'($urandom); c_gp_size = 3'($urandom); c_gp_full = 1'($urandom);
      c_prog_base = 16'($urandom); c_prog_size = 2'($urandom);
      c_act_hi    = 4'($urandom);
      for (int i = 0; i < 4; i++) c_str[i] = 2'($urandom);
      c_pf = 1'($urandom);
      pick = int'($urandom % 5);
      case (pick)
        0: a = int'(c_io_base[0]) ^ int'($urandom % 4096);
        1: a = int'(c_io_base[1]) ^ int'($urandom % 512);
        2: a = int'(c_gp_base) ^ int'($urandom % 16384);
        3: a = int'(c_prog_base) ^ int'($urandom % 16384);
        default: a = int'($urandom % 65536);
      endcase
      access(a & 16'hFFFF, 1'($urandom),
             (($urandom % 6) == 0) ? 4'($urandom) : 4'h0, "R5");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule